// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer Counter

This block is a general-purpose timer core. A programmable prescaler divides the system clock into count ticks. On each tick a counter moves against an auto-reload limit. The counter has three modes. Up mode runs 0..limit and wraps to 0. Down mode runs from the limit to 0 and reloads the limit. Center-aligned mode climbs to the limit and then descends back to 0. Each wrap, reload or turnaround raises an update event. The event appears as a one-cycle pulse for downstream capture, compare or PWM channels, and it also sets a sticky flag. Software must clear that flag. An interrupt request is raised while the flag is set and the interrupt is enabled.

Software reaches the block through a narrow write port. A select code picks one register, and the data word carries the value. A separate strobe clears the flag. The `en` input starts the timer and stops it. The live count is exported on every cycle.

Top module: `updown_timer`

## Requirements
- R1: After synchronous reset, `count`=0, `update`=0, `uif`=0 and `irq`=0. The limit resets to all ones, the prescale value to 0, and all control bits to 0.
- R2: In up mode (mode field 00, direction bit 0), each tick adds 1 to the count. A tick taken while the count is at or above the limit loads 0 and produces an update event.
- R3: In down mode (mode field 00, direction bit 1), each tick subtracts 1 from the count. A tick taken at count 0 loads the current limit and produces an update event.
- R4: Any non-zero mode field selects center-aligned counting. For a limit of 4 the sequence is 0,1,2,3,4,3,2,1,0,1,... An update event occurs at the top turnaround (limit to limit-1) and at the bottom turnaround (0 to 1). With a limit of 0 the count stays at 0 and every tick is an update event.
- R5: With prescale value P, a tick occurs once every P+1 enabled cycles (P=0 means every cycle). The prescale phase restarts from zero whenever `en` is low.
- R6: While `en` is low, the count holds and `update` stays 0. Register writes are still accepted during this time.
- R7: Writes use `wr_sel` as follows: 0 sets the limit, 1 sets the prescale value, 2 sets the count, and 3 sets control. The control word uses bit0 for direction, bits 2:1 for the mode field and bit3 for interrupt enable. A count write appears on `count` after the next clock. It takes priority over a tick in that cycle and produces no update event. A control write also returns the center-aligned phase to rising. A limit write applies from the next tick, with no shadow copy.
- R8: `update` is high for exactly the cycle after an update event, and `uif` becomes 1 in that same cycle. `uif` stays 1 until `uif_clr` is asserted. If a clear and an event fall in the same cycle, the event wins.
- R9: `irq` equals `uif` AND the interrupt-enable control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer run enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 limit, 1 prescale, 2 count, 3 control |
| wr_data | input | W | Write data |
| uif_clr | input | 1 | Clears the sticky update flag |
| count | output | W | Current counter value |
| update | output | 1 | One-cycle update event pulse |
| uif | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions in the same cycle matter most. The first is a software flag clear against a fresh update event. The bench loads the count at the limit, then enables the timer while asserting `uif_clr`, and expects `uif` to remain 1. The second is a count write against a tick that would have wrapped. Here the written value must appear with no `update` pulse. Random traffic reaches both collisions as well, and a cycle-accurate bench model judges every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_PSC   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_MODE_LO = 1;
  localparam int CTRL_MODE_HI = 2;
  localparam int CTRL_UIE_BIT = 3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] psc,
  output logic          tick
);
  logic [PW-1:0] phase_q;

  assign tick = en && (phase_q >= psc);

  always_ff @(posedge clk) begin
    if (rst || !en) phase_q <= '0;
    else if (tick)  phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  // R5: a divided tick is never followed directly by another tick
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && psc != '0) |=> (!tick || psc == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         center,
  input  logic         dir_down,
  input  logic [W-1:0] limit,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         phase_clr,
  output logic [W-1:0] cnt,
  output logic         ev,
  output logic         upd
);
  logic         falling_q;
  logic [W-1:0] cnt_n;
  logic         falling_n;

  always_comb begin
    cnt_n     = cnt;
    falling_n = falling_q;
    ev        = 1'b0;
    if (ld) begin
      cnt_n = ld_val;
    end else if (tick) begin
      if (center) begin
        if (limit == '0) begin
          cnt_n = '0; falling_n = 1'b0; ev = 1'b1;
        end else if (!falling_q) begin
          if (cnt >= limit) begin
            cnt_n = cnt - 1'b1; falling_n = 1'b1; ev = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            cnt_n = {{(W-1){1'b0}}, 1'b1}; falling_n = 1'b0; ev = 1'b1;
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
      end else if (dir_down) begin
        if (cnt == '0) begin
          cnt_n = limit; ev = 1'b1;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end else begin
        if (cnt >= limit) begin
          cnt_n = '0; ev = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    end
    if (phase_clr) falling_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      falling_q <= 1'b0;
      upd       <= 1'b0;
    end else begin
      cnt       <= cnt_n;
      falling_q <= falling_n;
      upd       <= ev;
    end
  end

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !center && !dir_down && cnt >= limit) |=> (cnt == '0 && upd));
  p_down_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !center && dir_down && cnt == '0) |=> (cnt == $past(limit) && upd));
  p_center_top_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && center && limit != '0 && !falling_q && cnt >= limit)
      |=> (upd && cnt == $past(cnt) - 1'b1));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> ($stable(cnt) && !upd));
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val) && !upd));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic clr,
  input  logic uie,
  output logic uif,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) uif <= 1'b0;
    else     uif <= ev | (uif & ~clr);
  end

  assign irq = uif & uie;

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (uif && !clr) |=> uif);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ev |=> uif);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !uif);
endmodule

// File: rtl/updown_timer.sv
module updown_timer #(
  parameter int W  = 16,
  parameter int PW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         uif_clr,
  output logic [W-1:0] count,
  output logic         update,
  output logic         uif,
  output logic         irq
);
  import timer_pkg::*;

  localparam int PSC_BITS = (PW < W) ? PW : W;

  logic [W-1:0]  limit_q;
  logic [PW-1:0] psc_q;
  logic          dir_q, uie_q;
  logic [1:0]    mode_q;
  logic          tick, ev;
  logic          wr_limit, wr_psc, wr_count, wr_ctrl;

  assign wr_limit = wr_en && (wr_sel == SEL_LIMIT);
  assign wr_psc   = wr_en && (wr_sel == SEL_PSC);
  assign wr_count = wr_en && (wr_sel == SEL_COUNT);
  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '1;
      psc_q   <= '0;
      dir_q   <= 1'b0;
      mode_q  <= 2'b00;
      uie_q   <= 1'b0;
    end else begin
      if (wr_limit) limit_q <= wr_data;
      if (wr_psc) begin
        psc_q <= '0;
        psc_q[PSC_BITS-1:0] <= wr_data[PSC_BITS-1:0];
      end
      if (wr_ctrl) begin
        dir_q  <= wr_data[CTRL_DIR_BIT];
        mode_q <= wr_data[CTRL_MODE_HI:CTRL_MODE_LO];
        uie_q  <= wr_data[CTRL_UIE_BIT];
      end
    end
  end

  tmr_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst(rst), .en(en), .psc(psc_q), .tick(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .center(mode_q != 2'b00), .dir_down(dir_q),
    .limit(limit_q), .ld(wr_count), .ld_val(wr_data),
    .phase_clr(wr_ctrl),
    .cnt(count), .ev(ev), .upd(update)
  );

  tmr_flags u_flags (
    .clk(clk), .rst(rst), .ev(ev), .clr(uif_clr), .uie(uie_q),
    .uif(uif), .irq(irq)
  );

  // R6: disabled timer produces no update pulse
  p_no_update_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_count) |=> !update);
endmodule

// File: tb/tb_updown_timer.sv
module tb_updown_timer;
  localparam int W = 16;
  localparam int PW = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, wr_en = 1'b0, uif_clr = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic update, uif, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_limit, m_cnt;
  logic [PW-1:0] m_psc, m_pc;
  logic m_dir, m_uie, m_fall, m_uif, m_upd;
  logic [1:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_timer #(.W(W), .PW(PW)) dut (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .uif_clr(uif_clr), .count(count), .update(update),
    .uif(uif), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    if (m_mode != 2'b00) return "R4";
    return m_dir ? "R3" : "R2";
  endfunction

  task automatic model_reset();
    m_limit = '1; m_cnt = '0; m_psc = '0; m_pc = '0;
    m_dir = 0; m_uie = 0; m_fall = 0; m_uif = 0; m_upd = 0; m_mode = 2'b00;
  endtask

  // advance the model by one clock using the currently driven inputs
  task automatic model_step();
    logic tk, ev, ld;
    logic [W-1:0] nc;
    logic nf;
    tk = en && (m_pc >= m_psc);
    ld = wr_en && wr_sel == 2'd2;
    nc = m_cnt; nf = m_fall; ev = 0;
    if (ld) nc = wr_data;
    else if (tk) begin
      if (m_mode != 2'b00) begin
        if (m_limit == 0) begin nc = 0; nf = 0; ev = 1; end
        else if (!m_fall) begin
          if (m_cnt >= m_limit) begin nc = m_cnt - 1; nf = 1; ev = 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nc = 1; nf = 0; ev = 1; end
          else nc = m_cnt - 1;
        end
      end else if (m_dir) begin
        if (m_cnt == 0) begin nc = m_limit; ev = 1; end else nc = m_cnt - 1;
      end else begin
        if (m_cnt >= m_limit) begin nc = 0; ev = 1; end else nc = m_cnt + 1;
      end
    end
    if (!en || tk) m_pc = '0; else m_pc = m_pc + 1;
    if (wr_en && wr_sel == 2'd3) begin
      nf = 0; m_dir = wr_data[0]; m_mode = wr_data[2:1]; m_uie = wr_data[3];
    end
    if (wr_en && wr_sel == 2'd0) m_limit = wr_data;
    if (wr_en && wr_sel == 2'd1) m_psc = PW'(wr_data);
    m_uif = ev | (m_uif & ~uif_clr);
    m_upd = ev; m_cnt = nc; m_fall = nf;
  endtask

  task automatic cycle();
    string t;
    t = mode_tag();
    model_step();
    @(posedge clk); #1;
    chk({t, " count"}, count, m_cnt);
    chk("R8 update", update, m_upd);
    chk("R8 uif", uif, m_uif);
    chk("R9 irq", irq, m_uif & m_uie);
    wr_en = 0; uif_clr = 0;
  endtask

  task automatic wr(input int sel, input int val);
    wr_en = 1; wr_sel = 2'(sel); wr_data = W'(val);
    cycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seq [10] = '{1, 2, 3, 4, 3, 2, 1, 0, 1, 2};
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1 count", count, 0); chk("R1 update", update, 0);
    chk("R1 uif", uif, 0); chk("R1 irq", irq, 0);

    // R4 center-aligned sequence with limit 4
    wr(0, 4); wr(3, 32'h2 | 32'h8); wr(2, 0);
    en = 1;
    for (int i = 0; i < 10; i++) begin
      cycle();
      chk("R4 sequence", count, seq[i]);
    end
    en = 0; cycle();

    // R2 up wrap with limit 3, prescale 2 (R5)
    wr(3, 32'h8); wr(0, 3); wr(1, 2); wr(2, 0);
    en = 1; repeat (20) cycle();
    en = 0; repeat (3) cycle();           // R6 hold
    en = 1; repeat (5) cycle();           // R5 phase restart

    // R3 down reload
    wr(1, 0); wr(3, 32'h1); wr(0, 5); wr(2, 1);
    repeat (10) cycle();

    // R8 clear vs event in the same cycle: up mode, count at limit
    wr(3, 32'h0); wr(0, 2); en = 0; uif_clr = 1; cycle();
    wr(2, 2); en = 1; uif_clr = 1; cycle();
    chk("R8 set beats clear", uif, 1);
    uif_clr = 1; cycle(); chk("R8 cleared", uif, 0);

    // R7 count write while a wrapping tick is due
    wr(2, 2); wr(2, 7); chk("R7 load no update", update, 0);
    chk("R7 load value", count, 7);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      en = ($urandom_range(0, 9) != 0);
      uif_clr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1; wr_sel = 2'($urandom_range(0, 3));
        case (wr_sel)
          2'd0: wr_data = W'($urandom_range(0, 7));
          2'd1: wr_data = W'($urandom_range(0, 3));
          2'd2: wr_data = W'($urandom_range(0, 9));
          default: wr_data = W'($urandom_range(0, 15));
        endcase
      end
      cycle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule